// File: doc/BRIEF.md
# Selective Victim Bank

This block is an extra storage bank placed beside a banked, non-uniform shared cache. When the main cache evicts a line, it presents the line address, data, dirty flag and a two-bit class code naming the kind of bank the line left. An insertion filter keeps only lines that left a local-class bank. Every other victim goes straight to the memory writeback port, so lines that are seldom reused do not pollute the bank.

The bank is set-associative: each line may live only in the set picked by its index bits. When the main cache misses, it presents the address on the lookup port. A hit returns the stored line one cycle later for reinsertion and frees the entry. A miss raises a flag so that the request can go on to memory.

Inside a full set the bank replaces the way that was filled longest ago. A dirty line pushed out this way is written back, and a clean one is dropped. The writeback port uses a valid/ready handshake and holds at most one line. While that line is pending, new victims are refused.

Top module: `victim_bank`

## Requirements
- R1: After synchronous reset every entry is invalid, `wb_valid`, `lk_hit` and `lk_miss` are 0, and `ev_ready` is 1 while no lookup is requested.
- R2: A victim accepted with `ev_origin` 1, 2 or 3 is not stored. In the next cycle `wb_valid` is 1, `wb_addr` is the victim address with bits [5:0] cleared, and `wb_data` and `wb_dirty` equal the victim's data and dirty flag.
- R3: A victim accepted with `ev_origin` 0 (local class) is stored in set `addr[11:6]` with tag `addr[31:12]`. Up to 4 lines of one set coexist, and lines of other sets do not disturb them.
- R4: A local victim fills the lowest-numbered invalid way of its set. If all 4 ways are valid, it replaces the valid line that was inserted least recently.
- R5: A dirty line displaced by R4 appears on the writeback port one cycle after the insertion, with its own address and data and `wb_dirty`=1. A clean displaced line is dropped and `wb_valid` stays 0.
- R6: A lookup whose address bits [31:6] match a stored line gives `lk_hit`=1, `lk_miss`=0, and the line's data and dirty flag in the cycle after the request. The entry is then invalid, so a repeated lookup misses.
- R7: A lookup that matches no stored line gives `lk_miss`=1 and `lk_hit`=0 in the cycle after the request. Both flags are 0 in a cycle after no request.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, the writeback address, data and dirty flag hold steady and `ev_ready` is 0. A victim offered in those cycles is not taken.
- R9: In any cycle with `lk_valid`=1, `ev_ready` is 0 and a victim offered in that cycle is not taken.
- R10: A local victim whose address is already stored overwrites that entry. No second copy is made and no line is displaced. The stored dirty flag becomes the OR of the old and new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Victim offered by the main cache |
| ev_ready | output | 1 | Bank can take a victim this cycle |
| ev_addr | input | 32 | Victim byte address |
| ev_data | input | 64 | Victim line data |
| ev_dirty | input | 1 | Victim is modified |
| ev_origin | input | 2 | Class of the evicting bank, 0 = local |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup found the line (one cycle later) |
| lk_miss | output | 1 | Lookup missed (one cycle later) |
| lk_data | output | 64 | Returned line data on a hit |
| lk_dirty | output | 1 | Returned dirty flag on a hit |
| wb_valid | output | 1 | Writeback line pending |
| wb_ready | input | 1 | Memory accepts the writeback |
| wb_addr | output | 32 | Writeback line address |
| wb_data | output | 64 | Writeback line data |
| wb_dirty | output | 1 | Writeback line is modified |

## Verification
The victim stream mixes the four origin classes. This separates the filter's keep path from the bypass path, and a stored line is told apart from a forwarded one by looking it up afterwards. One set is filled past its four ways, with lookups between the insertions that leave an invalid hole. This exposes the difference between filling the lowest invalid way first and strict insertion order, and it checks that a dirty displaced line is written back while a clean one is not. Repeated lookups, a reinsert of an address already present, and a line in a second set show invalidation on hit, the absence of duplicate copies, and the independence of sets. A writeback held off by `wb_ready`, and a victim offered in the same cycle as a lookup, show that stalled victims are really dropped rather than stored late.

// File: rtl/vb_pkg.sv
`timescale 1ns/1ps
package vb_pkg;
    parameter int ADDR_W   = 32;
    parameter int DATA_W   = 64;
    parameter int WAYS     = 4;
    parameter int SETS     = 64;
    parameter int LINE_OFF = 6;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam int TAG_W  = LINE_W - IDX_W;

    // class codes of the evicting bank
    typedef enum logic [1:0] {
        SRC_LOCAL   = 2'd0,
        SRC_CENTRAL = 2'd1,
        SRC_REMOTE  = 2'd2,
        SRC_SPARE   = 2'd3
    } src_class_t;

    // only local-class victims are admitted by default
    localparam logic [3:0] ADMIT_MASK = 4'b0001;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
        logic              dirty;
    } wb_req_t;

    function automatic logic [ADDR_W-1:0] line_to_addr(input logic [LINE_W-1:0] line);
        return {line, {LINE_OFF{1'b0}}};
    endfunction
endpackage

// File: rtl/vb_filter.sv
`timescale 1ns/1ps
module vb_filter #(
    parameter logic [3:0] MASK = 4'b0001
) (
    input  logic [1:0] origin,
    output logic       admit
);
    assign admit = MASK[origin];
endmodule

// File: rtl/vb_match.sv
`timescale 1ns/1ps
module vb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == tag);
    end

    assign hit = |eq;

    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/vb_repl.sv
`timescale 1ns/1ps
module vb_repl #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic                       force_hit,
    input  logic [WAY_W-1:0]           force_way,
    output logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][WAY_W-1:0] ages_next
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] free_way;
    logic             free_found;
    logic [WAY_W-1:0] old_way;

    always_comb begin
        free_way   = '0;
        free_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_way   = WAY_W'(w);
                free_found = 1'b1;
            end
        end
    end

    always_comb begin
        old_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == OLDEST) old_way = WAY_W'(w);
        end
    end

    always_comb begin
        if (force_hit)       way = force_way;
        else if (free_found) way = free_way;
        else                 way = old_way;
    end

    // ages form a permutation: the chosen way becomes youngest,
    // every way younger than it grows one step older
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way)        ages_next[w] = '0;
            else if (ages[w] < ages[way]) ages_next[w] = ages[w] + 1'b1;
            else                          ages_next[w] = ages[w];
        end
    end
endmodule

// File: rtl/victim_bank.sv
`timescale 1ns/1ps
module victim_bank
    import vb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_dirty,
    input  logic [1:0]        ev_origin,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_dirty
);
    slot_t                       mem   [SETS][WAYS];
    logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

    wb_req_t           wb_q;
    logic              hit_q, miss_q, rdirty_q;
    logic [DATA_W-1:0] rdata_q;

    // address split
    logic [IDX_W-1:0] ev_idx, lk_idx;
    logic [TAG_W-1:0] ev_tag, lk_tag;
    logic [LINE_W-1:0] ev_line;
    logic unused_offset_bits;

    assign ev_line = ev_addr[ADDR_W-1:LINE_OFF];
    assign ev_idx  = ev_addr[LINE_OFF +: IDX_W];
    assign ev_tag  = ev_addr[ADDR_W-1 -: TAG_W];
    assign lk_idx  = lk_addr[LINE_OFF +: IDX_W];
    assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset_bits = ^{ev_addr[LINE_OFF-1:0], lk_addr[LINE_OFF-1:0]};

    // row views of the addressed sets
    logic [WAYS-1:0]            ev_vld, lk_vld;
    logic [WAYS-1:0][TAG_W-1:0] ev_tags, lk_tags;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            ev_vld[w]  = mem[ev_idx][w].valid;
            ev_tags[w] = mem[ev_idx][w].tag;
            lk_vld[w]  = mem[lk_idx][w].valid;
            lk_tags[w] = mem[lk_idx][w].tag;
        end
    end

    // insertion filter
    logic admit;
    vb_filter #(.MASK(ADMIT_MASK)) i_filter (
        .origin (ev_origin),
        .admit  (admit)
    );

    // duplicate detection on the victim path
    logic             dup_hit;
    logic [WAY_W-1:0] dup_way;
    vb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_ev_match (
        .valid (ev_vld),
        .tags  (ev_tags),
        .tag   (ev_tag),
        .hit   (dup_hit),
        .way   (dup_way)
    );

    // lookup path
    logic             lk_match;
    logic [WAY_W-1:0] lk_way;
    vb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lk_match (
        .valid (lk_vld),
        .tags  (lk_tags),
        .tag   (lk_tag),
        .hit   (lk_match),
        .way   (lk_way)
    );

    // placement choice
    logic [WAY_W-1:0]           ins_way;
    logic [WAYS-1:0][WAY_W-1:0] ages_upd;
    vb_repl #(.WAYS(WAYS)) i_repl (
        .valid     (ev_vld),
        .ages      (age_q[ev_idx]),
        .force_hit (dup_hit),
        .force_way (dup_way),
        .way       (ins_way),
        .ages_next (ages_upd)
    );

    // control
    logic  ev_take, ins, bypass, spill;
    slot_t victim_slot, lk_slot, new_slot;

    assign ev_ready    = !wb_q.valid && !lk_valid;
    assign ev_take     = ev_valid && ev_ready;
    assign ins         = ev_take && admit;
    assign bypass      = ev_take && !admit;
    assign victim_slot = mem[ev_idx][ins_way];
    assign lk_slot     = mem[lk_idx][lk_way];
    assign spill       = ins && !dup_hit && victim_slot.valid && victim_slot.dirty;

    always_comb begin
        new_slot.valid = 1'b1;
        new_slot.dirty = ev_dirty || (dup_hit && victim_slot.dirty);
        new_slot.tag   = ev_tag;
        new_slot.data  = ev_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q     <= '0;
            hit_q    <= 1'b0;
            miss_q   <= 1'b0;
            rdata_q  <= '0;
            rdirty_q <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem[s][w]   <= '0;
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else begin
            if (wb_q.valid && wb_ready) wb_q.valid <= 1'b0;

            if (bypass) begin
                wb_q <= '{valid: 1'b1, line: ev_line, data: ev_data, dirty: ev_dirty};
            end else if (spill) begin
                wb_q <= '{valid: 1'b1, line: {victim_slot.tag, ev_idx},
                          data: victim_slot.data, dirty: 1'b1};
            end

            if (ins) begin
                mem[ev_idx][ins_way] <= new_slot;
                age_q[ev_idx]        <= ages_upd;
            end

            hit_q  <= lk_valid && lk_match;
            miss_q <= lk_valid && !lk_match;
            if (lk_valid && lk_match) begin
                rdata_q  <= lk_slot.data;
                rdirty_q <= lk_slot.dirty;
                mem[lk_idx][lk_way].valid <= 1'b0;
            end else begin
                rdata_q  <= '0;
                rdirty_q <= 1'b0;
            end
        end
    end

    assign lk_hit   = hit_q;
    assign lk_miss  = miss_q;
    assign lk_data  = rdata_q;
    assign lk_dirty = rdirty_q;
    assign wb_valid = wb_q.valid;
    assign wb_addr  = line_to_addr(wb_q.line);
    assign wb_data  = wb_q.data;
    assign wb_dirty = wb_q.dirty;
endmodule

// File: rtl/vb_checker.sv
`timescale 1ns/1ps
module vb_checker
    import vb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [ADDR_W-1:0] ev_addr,
    input logic [DATA_W-1:0] ev_data,
    input logic              ev_dirty,
    input logic [1:0]        ev_origin,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [DATA_W-1:0] lk_data,
    input logic              lk_dirty,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic              wb_dirty
);
    logic unused_chk;
    assign unused_chk = ^{lk_addr, lk_data, lk_dirty};

    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!wb_valid && !lk_hit && !lk_miss));

    assert_bypass_fwd_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready && ev_origin != 2'd0) |=>
        (wb_valid && wb_addr[ADDR_W-1:LINE_OFF] == $past(ev_addr[ADDR_W-1:LINE_OFF])
         && wb_data == $past(ev_data) && wb_dirty == $past(ev_dirty)));

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (lk_hit != lk_miss));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!lk_hit && !lk_miss));

    assert_wb_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=>
        (wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_dirty)));

    assert_wb_stall_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !ev_ready);

    assert_lk_first_R9: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> !ev_ready);
endmodule

bind victim_bank vb_checker i_vb_checker (.*);

// File: tb/test_victim_bank.sv
`timescale 1ns/1ps
module test_victim_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid, ev_ready, ev_dirty;
    logic [31:0] ev_addr;
    logic [63:0] ev_data;
    logic [1:0]  ev_origin;
    logic        lk_valid, lk_hit, lk_miss, lk_dirty;
    logic [31:0] lk_addr;
    logic [63:0] lk_data;
    logic        wb_valid, wb_ready, wb_dirty;
    logic [31:0] wb_addr;
    logic [63:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    victim_bank i_victim_bank (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
        .ev_data(ev_data), .ev_dirty(ev_dirty), .ev_origin(ev_origin),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_data(lk_data), .lk_dirty(lk_dirty),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_dirty(wb_dirty)
    );

    typedef struct packed {
        logic        op;       // 0 victim, 1 lookup
        logic [31:0] addr;
        logic [15:0] data;
        logic        dirty;
        logic [1:0]  org;
        logic        exp_flag; // writeback expected / hit expected
        logic [31:0] exp_addr;
        logic [15:0] exp_data;
        logic        exp_dirty;
        logic [23:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_1140, 16'h0011, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R3 "},
        '{1'b0, 32'h0000_2140, 16'h0022, 1'b1, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R3 "},
        '{1'b0, 32'h0000_3147, 16'h0033, 1'b0, 2'd1, 1'b1, 32'h0000_3140, 16'h0033, 1'b0, "R2 "},
        '{1'b1, 32'h0000_117F, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0011, 1'b0, "R6 "},
        '{1'b1, 32'h0000_1140, 16'h0,    1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R6 "},
        '{1'b1, 32'h0000_3140, 16'h0,    1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R2 "},
        '{1'b0, 32'h0000_3140, 16'h0033, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R4 "},
        '{1'b0, 32'h0000_4140, 16'h0044, 1'b1, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R4 "},
        '{1'b0, 32'h0000_5140, 16'h0055, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R4 "},
        '{1'b0, 32'h0000_6140, 16'h0066, 1'b0, 2'd0, 1'b1, 32'h0000_2140, 16'h0022, 1'b1, "R5 "},
        '{1'b0, 32'h0000_7140, 16'h0077, 1'b1, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R5 "},
        '{1'b1, 32'h0000_2140, 16'h0,    1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R4 "},
        '{1'b1, 32'h0000_3140, 16'h0,    1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R4 "},
        '{1'b1, 32'h0000_4140, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0044, 1'b1, "R4 "},
        '{1'b0, 32'h0000_1180, 16'h0088, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R3 "},
        '{1'b1, 32'h0000_1180, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0088, 1'b0, "R3 "},
        '{1'b0, 32'h0000_5140, 16'h0099, 1'b1, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R10"},
        '{1'b1, 32'h0000_5140, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0099, 1'b1, "R10"},
        '{1'b1, 32'h0000_5140, 16'h0,    1'b0, 2'd0, 1'b0, 32'h0, 16'h0,    1'b0, "R10"},
        '{1'b0, 32'h0000_9140, 16'h00AA, 1'b1, 2'd2, 1'b1, 32'h0000_9140, 16'h00AA, 1'b1, "R2 "},
        '{1'b0, 32'h0000_A15F, 16'h00BB, 1'b0, 2'd3, 1'b1, 32'h0000_A140, 16'h00BB, 1'b0, "R2 "},
        '{1'b1, 32'h0000_6140, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0066, 1'b0, "R4 "},
        '{1'b1, 32'h0000_7140, 16'h0,    1'b0, 2'd0, 1'b1, 32'h0, 16'h0077, 1'b1, "R4 "}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_victim(input logic [31:0] a, input logic [63:0] d,
                             input logic dy, input logic [1:0] o);
        @(negedge clk);
        ev_valid = 1'b1; ev_addr = a; ev_data = d; ev_dirty = dy; ev_origin = o;
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic drain();
        if (wb_valid) begin
            wb_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wb_ready = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ev_valid = 1'b0; ev_addr = '0; ev_data = '0; ev_dirty = 1'b0;
        ev_origin = 2'd0; lk_valid = 1'b0; lk_addr = '0; wb_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", {63'd0, wb_valid}, 64'd0);
        chk("R1", {62'd0, lk_hit, lk_miss}, 64'd0);
        chk("R1", {63'd0, ev_ready}, 64'd1);
        do_lookup(32'h0000_1140);
        chk("R1", {62'd0, lk_hit, lk_miss}, 64'd1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string r;
            v = VECS[i];
            r = $sformatf("%s vec %0d", v.req, i);
            if (v.op == 1'b0) begin
                do_victim(v.addr, {48'd0, v.data}, v.dirty, v.org);
                chk(r, {63'd0, wb_valid}, {63'd0, v.exp_flag});
                if (v.exp_flag) begin
                    chk(r, {32'd0, wb_addr}, {32'd0, v.exp_addr});
                    chk(r, wb_data, {48'd0, v.exp_data});
                    chk(r, {63'd0, wb_dirty}, {63'd0, v.exp_dirty});
                end
                drain();
            end else begin
                do_lookup(v.addr);
                chk(r, {62'd0, lk_hit, lk_miss}, v.exp_flag ? 64'd2 : 64'd1);
                if (v.exp_flag) begin
                    chk(r, lk_data, {48'd0, v.exp_data});
                    chk(r, {63'd0, lk_dirty}, {63'd0, v.exp_dirty});
                end
            end
        end

        // R7 flags quiet with no request
        @(negedge clk);
        chk("R7", {62'd0, lk_hit, lk_miss}, 64'd0);

        // R8 held writeback, stalled victim not taken
        do_victim(32'h0000_B140, 64'hCC, 1'b1, 2'd1);
        ev_valid = 1'b1; ev_addr = 32'h0000_C140; ev_data = 64'hDD;
        ev_dirty = 1'b0; ev_origin = 2'd0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8", {63'd0, wb_valid}, 64'd1);
            chk("R8", {32'd0, wb_addr}, 64'h0000_B140);
            chk("R8", wb_data, 64'hCC);
            chk("R8", {63'd0, ev_ready}, 64'd0);
        end
        ev_valid = 1'b0;
        drain();
        chk("R8", {63'd0, ev_ready}, 64'd1);
        do_lookup(32'h0000_C140);
        chk("R8", {62'd0, lk_hit, lk_miss}, 64'd1);

        // R9 lookup blocks a same-cycle victim
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h0000_D140;
        ev_valid = 1'b1; ev_addr = 32'h0000_E140; ev_data = 64'hEE;
        ev_dirty = 1'b0; ev_origin = 2'd0;
        #1;
        chk("R9", {63'd0, ev_ready}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; ev_valid = 1'b0;
        chk("R9", {62'd0, lk_hit, lk_miss}, 64'd1);
        do_lookup(32'h0000_E140);
        chk("R9", {62'd0, lk_hit, lk_miss}, 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule